// File: doc/BRIEF.md
# Ethernet Pause Frame Generator

This block sits in front of a 64-bit packet transmit stream and inserts IEEE 802.3x flow-control frames into it. Client traffic passes straight through to the transmit side while no pause frame is being sent. A pause frame is asked for either on a 2-bit request input or by writing a command word into a small register file. The same register file holds the enable bit, the pause quanta and the 48-bit station address.

A request is latched as pending. A frame starts only when three conditions hold: the generator is enabled, no client packet is open, and no other pause frame is in flight. While a pause frame is selected, the client is held off with its ready low.

Each frame is 60 bytes and carries no FCS. It goes out as eight beats with start, end and empty markers. The block honours the downstream ready on every beat.

Top module: `pause_frame_gen`

## Requirements
- R1: After reset, txValid is 0, every register reads 0 and, with no pending request, cliReady equals txReady.
- R2: A cycle with reqIn[1] high latches a pending XOFF request and a cycle with reqIn[0] high latches a pending XON request. Each pending request produces exactly one frame of its kind.
- R3: The command register sits at address 0. A write sets bit 0 (XON) and bit 1 (XOFF) where the written data has ones and never clears a bit. A set bit reads back as 1 until the final beat of a frame of that kind is accepted, and it reads 0 from the next cycle on.
- R4: The enable bit is bit 0 of address 1. While it is 0 no frame starts and pending requests are kept. Once it is set, the pending frame starts.
- R5: The frame bytes are sent first byte on data[63:56]. Bytes 0-5 are 01-80-C2-00-00-01. Bytes 6-7 are bits [15:8] and [7:0] of the high address register (address 4). Bytes 8-11 are the low address register (address 3), most significant byte first. Bytes 12-13 are 88 08, bytes 14-15 are 00 01, bytes 16-17 are the quanta, and bytes 18-59 are zero.
- R6: An XOFF frame carries the quanta register (address 2, bits [15:0]) and an XON frame carries quanta 0.
- R7: A frame is eight beats. txSop is high on the first beat only. txEop is high on the eighth beat only, with txEmpty 4 on that beat and 0 on the other beats.
- R8: No frame starts while a client packet is open, meaning a packet whose start has been accepted and whose end has not. A waiting request is served after the client's end-of-packet. While a pause frame is selected, cliReady is 0.
- R9: When XON and XOFF are both pending, XOFF is sent first and XON follows.
- R10: While txReady is low, the pause beat on the outputs is held unchanged. Each beat advances only when it is accepted, so no beat is lost or repeated.
- R11: When no pause frame is selected, the tx outputs equal the client inputs and cliReady equals txReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 2 | Request pins: bit 0 XON, bit 1 XOFF |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| cliValid | input | 1 | Client beat valid |
| cliReady | output | 1 | Client beat accepted when high with cliValid |
| cliSop | input | 1 | Client start of packet |
| cliEop | input | 1 | Client end of packet |
| cliData | input | 64 | Client data |
| cliEmpty | input | 3 | Client empty byte count on end beat |
| txValid | output | 1 | Transmit beat valid |
| txReady | input | 1 | Downstream ready |
| txSop | output | 1 | Transmit start of packet |
| txEop | output | 1 | Transmit end of packet |
| txData | output | 64 | Transmit data |
| txEmpty | output | 3 | Transmit empty byte count |

## Verification
Requests are driven from each source alone and from both pins in the same cycle. Separate runs send one XOFF, one XON, and an XON and XOFF together, which shows whether the frame kind follows the source and whether the priority rule holds. A request is placed while a multi-beat client packet is open, and another lands in the same cycle as a client start, which separates waiting for the end of the client packet from arbitration at the start boundary. Irregular backpressure during a frame with a non-default quanta separates correct beat holding from dropped or repeated beats. A request made while disabled shows that pending state survives until enable is set.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int DATA_W      = 64;
  localparam int MIN_BYTES   = 60;
  localparam int QUANTA_W    = 16;
  localparam int ADDR_W      = 3;
  localparam int REG_W       = 32;
  localparam int BEAT_BYTES  = DATA_W / 8;
  localparam int FRAME_BEATS = (MIN_BYTES + BEAT_BYTES - 1) / BEAT_BYTES;
  localparam int BEAT_W      = $clog2(FRAME_BEATS);
  localparam int EMPTY_W     = $clog2(BEAT_BYTES);
  localparam int LAST_EMPTY  = FRAME_BEATS * BEAT_BYTES - MIN_BYTES;

  localparam logic [ADDR_W-1:0] ADDR_CMD    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_EN     = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_QUANTA = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MAC_LO = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MAC_HI = 3'd4;

  typedef enum logic {ST_IDLE, ST_SEND} pfg_state_e;

  typedef struct packed {
    logic              sel;
    logic [BEAT_W-1:0] beat;
    logic              xoff;
  } pfg_strobe_t;
endpackage

// File: rtl/pfg_regs.sv
module pfg_regs
  import pfg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  input  logic [1:0]          cmdClr,
  output logic [1:0]          cmdBits,
  output logic                enable,
  output logic [QUANTA_W-1:0] quanta,
  output logic [31:0]         macLo,
  output logic [15:0]         macHi,
  output logic [REG_W-1:0]    regRdData
);
  logic wrCmd;
  assign wrCmd = regWr && (regAddr == ADDR_CMD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdBits <= '0;
      enable  <= 1'b0;
      quanta  <= '0;
      macLo   <= '0;
      macHi   <= '0;
    end else begin
      cmdBits <= (cmdBits & ~cmdClr) | (wrCmd ? regWrData[1:0] : 2'b00);
      if (regWr) begin
        case (regAddr)
          ADDR_EN:     enable <= regWrData[0];
          ADDR_QUANTA: quanta <= regWrData[QUANTA_W-1:0];
          ADDR_MAC_LO: macLo  <= regWrData;
          ADDR_MAC_HI: macHi  <= regWrData[15:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CMD:    regRdData[1:0]          = cmdBits;
      ADDR_EN:     regRdData[0]            = enable;
      ADDR_QUANTA: regRdData[QUANTA_W-1:0] = quanta;
      ADDR_MAC_LO: regRdData               = macLo;
      ADDR_MAC_HI: regRdData[15:0]         = macHi;
      default:     regRdData               = '0;
    endcase
  end

  // R3: a completed frame clears its command bit unless a new write sets it again
  a_r3_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cmdClr[0] && !wrCmd) |=> !cmdBits[0]);
  a_r3_self_clear_xoff: assert property (@(posedge clk) disable iff (!rstN)
    (cmdClr[1] && !wrCmd) |=> !cmdBits[1]);
endmodule

// File: rtl/pfg_ctrl.sv
module pfg_ctrl
  import pfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  reqIn,
  input  logic [1:0]  cmdBits,
  input  logic        enable,
  input  logic        cliValid,
  input  logic        cliSop,
  input  logic        cliEop,
  input  logic        txReady,
  output pfg_strobe_t strobe,
  output logic [1:0]  cmdClr
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(FRAME_BEATS - 1);

  pfg_state_e        state;
  logic [1:0]        pinPend;
  logic [BEAT_W-1:0] beatR;
  logic              xoffR;
  logic              inFrame;

  logic [1:0] want;
  logic [1:0] doneMask;
  logic       startNow;
  logic       pickXoff;
  logic       lastAcc;
  logic       cliAcc;

  always_comb begin
    want        = pinPend | cmdBits;
    startNow    = (state == ST_IDLE) && (want != 2'b00) && enable && !inFrame;
    pickXoff    = want[1];
    strobe.sel  = (state == ST_SEND) || startNow;
    strobe.xoff = (state == ST_SEND) ? xoffR : pickXoff;
    strobe.beat = (state == ST_SEND) ? beatR : '0;
    lastAcc     = (state == ST_SEND) && txReady && (beatR == LAST_BEAT);
    doneMask    = lastAcc ? (xoffR ? 2'b10 : 2'b01) : 2'b00;
    cliAcc      = cliValid && txReady && !strobe.sel;
  end

  assign cmdClr = doneMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pinPend <= '0;
      beatR   <= '0;
      xoffR   <= 1'b0;
      inFrame <= 1'b0;
    end else begin
      pinPend <= (pinPend & ~doneMask) | reqIn;
      case (state)
        ST_IDLE: begin
          if (startNow) begin
            state <= ST_SEND;
            xoffR <= pickXoff;
            beatR <= txReady ? BEAT_W'(1) : '0;
          end
        end
        default: begin
          if (txReady) begin
            if (beatR == LAST_BEAT) begin
              state <= ST_IDLE;
              beatR <= '0;
            end else begin
              beatR <= beatR + 1'b1;
            end
          end
        end
      endcase
      if (cliAcc && cliSop && !cliEop) inFrame <= 1'b1;
      else if (cliAcc && cliEop)       inFrame <= 1'b0;
    end
  end

  // R8: a client packet that just opened keeps the generator off the line
  a_r8_open_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (cliValid && cliSop && !cliEop && txReady && !strobe.sel) |=> !strobe.sel);

  // R4: a frame only begins while enabled
  a_r4_start_enabled: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.sel) |-> enable);
endmodule

// File: rtl/pfg_datapath.sv
module pfg_datapath
  import pfg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  pfg_strobe_t         strobe,
  input  logic [31:0]         macLo,
  input  logic [15:0]         macHi,
  input  logic [QUANTA_W-1:0] quanta,
  input  logic                cliValid,
  output logic                cliReady,
  input  logic                cliSop,
  input  logic                cliEop,
  input  logic [DATA_W-1:0]   cliData,
  input  logic [EMPTY_W-1:0]  cliEmpty,
  output logic                txValid,
  input  logic                txReady,
  output logic                txSop,
  output logic                txEop,
  output logic [DATA_W-1:0]   txData,
  output logic [EMPTY_W-1:0]  txEmpty
);
  function automatic logic [7:0] hdrByte(input int idx, input logic [15:0] hi,
                                         input logic [31:0] lo,
                                         input logic [QUANTA_W-1:0] q);
    case (idx)
      0:  hdrByte = 8'h01;
      1:  hdrByte = 8'h80;
      2:  hdrByte = 8'hC2;
      5:  hdrByte = 8'h01;
      6:  hdrByte = hi[15:8];
      7:  hdrByte = hi[7:0];
      8:  hdrByte = lo[31:24];
      9:  hdrByte = lo[23:16];
      10: hdrByte = lo[15:8];
      11: hdrByte = lo[7:0];
      12: hdrByte = 8'h88;
      13: hdrByte = 8'h08;
      15: hdrByte = 8'h01;
      16: hdrByte = q[QUANTA_W-1 -: 8];
      17: hdrByte = q[7:0];
      default: hdrByte = 8'h00;
    endcase
  endfunction

  logic [QUANTA_W-1:0] quantaEff;
  logic [DATA_W-1:0]   pauseData;
  logic                pauseSop;
  logic                pauseEop;

  assign quantaEff = strobe.xoff ? quanta : '0;
  assign pauseSop  = (strobe.beat == '0);
  assign pauseEop  = (strobe.beat == BEAT_W'(FRAME_BEATS - 1));

  for (genvar lane = 0; lane < BEAT_BYTES; lane++) begin : g_lane
    assign pauseData[DATA_W-1-8*lane -: 8] =
      hdrByte(int'(strobe.beat) * BEAT_BYTES + lane, macHi, macLo, quantaEff);
  end

  always_comb begin
    if (strobe.sel) begin
      txValid  = 1'b1;
      txSop    = pauseSop;
      txEop    = pauseEop;
      txData   = pauseData;
      txEmpty  = pauseEop ? EMPTY_W'(LAST_EMPTY) : '0;
      cliReady = 1'b0;
    end else begin
      txValid  = cliValid;
      txSop    = cliSop;
      txEop    = cliEop;
      txData   = cliData;
      txEmpty  = cliEmpty;
      cliReady = txReady;
    end
  end

  // R10: a stalled pause beat stays on the outputs
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel && !txReady) |=> (txValid && $stable(txSop) && $stable(txEop) &&
      $stable(txEmpty) &&
      (!($stable(quanta) && $stable(macLo) && $stable(macHi)) || $stable(txData))));

  // R7: a new pause frame opens with a start marker
  a_r7_starts_sop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.sel) |-> txSop);

  // R7: after an accepted pause end beat, the line is released or a fresh frame opens
  a_r7_frame_bounds: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel && txReady && txEop) |=> (!strobe.sel || txSop));
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import pfg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         reqIn,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic               cliValid,
  output logic               cliReady,
  input  logic               cliSop,
  input  logic               cliEop,
  input  logic [DATA_W-1:0]  cliData,
  input  logic [EMPTY_W-1:0] cliEmpty,
  output logic               txValid,
  input  logic               txReady,
  output logic               txSop,
  output logic               txEop,
  output logic [DATA_W-1:0]  txData,
  output logic [EMPTY_W-1:0] txEmpty
);
  pfg_strobe_t         strobe;
  logic [1:0]          cmdClr;
  logic [1:0]          cmdBits;
  logic                enable;
  logic [QUANTA_W-1:0] quanta;
  logic [31:0]         macLo;
  logic [15:0]         macHi;

  pfg_regs u_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .cmdClr(cmdClr), .cmdBits(cmdBits), .enable(enable), .quanta(quanta),
    .macLo(macLo), .macHi(macHi), .regRdData(regRdData)
  );

  pfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .cmdBits(cmdBits), .enable(enable),
    .cliValid(cliValid), .cliSop(cliSop), .cliEop(cliEop), .txReady(txReady),
    .strobe(strobe), .cmdClr(cmdClr)
  );

  pfg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .macLo(macLo), .macHi(macHi),
    .quanta(quanta), .cliValid(cliValid), .cliReady(cliReady), .cliSop(cliSop),
    .cliEop(cliEop), .cliData(cliData), .cliEmpty(cliEmpty), .txValid(txValid),
    .txReady(txReady), .txSop(txSop), .txEop(txEop), .txData(txData), .txEmpty(txEmpty)
  );
endmodule

// File: tb/pause_frame_gen_bench.sv
module pause_frame_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  reqIn = '0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cliValid = 1'b0, cliSop = 1'b0, cliEop = 1'b0;
  logic [63:0] cliData = '0;
  logic [2:0]  cliEmpty = '0;
  logic        cliReady;
  logic        txValid, txSop, txEop;
  logic        txReady = 1'b1;
  logic [63:0] txData;
  logic [2:0]  txEmpty;

  pause_frame_gen u_pause_frame_gen (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cliValid(cliValid),
    .cliReady(cliReady), .cliSop(cliSop), .cliEop(cliEop), .cliData(cliData),
    .cliEmpty(cliEmpty), .txValid(txValid), .txReady(txReady), .txSop(txSop),
    .txEop(txEop), .txData(txData), .txEmpty(txEmpty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  // reference state
  logic [1:0]  mPin = '0, mCmd = '0;
  logic        mEn = 0, mInFrame = 0, mSend = 0, mXoff = 0;
  logic [15:0] mQ = '0, mHi = '0;
  logic [31:0] mLo = '0;
  int          mBeat = 0;
  int          obsCnt = 0;
  logic [15:0] seenQ[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] refBeat(input int b, input logic xo);
    logic [143:0] h;
    logic [63:0]  r;
    h = {48'h0180C2000001, mHi, mLo, 16'h8808, 16'h0001, (xo ? mQ : 16'h0000)};
    r = '0;
    for (int k = 0; k < 8; k++) begin
      int idx;
      idx = b * 8 + k;
      if (idx < 18) r[63-8*k -: 8] = h[143-8*idx -: 8];
    end
    return r;
  endfunction

  // compare current cycle, advance reference, wait one clock
  task automatic step();
    logic [1:0]  want, dm;
    logic        start, xo, sel, done, cliAcc;
    logic [31:0] expRd;
    int          b;
    #1;
    want  = mPin | mCmd;
    start = !mSend && (want != 2'b00) && mEn && !mInFrame;
    xo    = mSend ? mXoff : want[1];
    b     = mSend ? mBeat : 0;
    sel   = mSend || start;
    case (regAddr)
      3'd0: expRd = {30'b0, mCmd};
      3'd1: expRd = {31'b0, mEn};
      3'd2: expRd = {16'b0, mQ};
      3'd3: expRd = mLo;
      3'd4: expRd = {16'b0, mHi};
      default: expRd = '0;
    endcase
    if (regAddr == 3'd0)      chk("R3 cmd readback", regRdData, expRd);
    else if (regAddr == 3'd1) chk("R4 enable readback", regRdData, expRd);
    else                      chk("R5 register readback", regRdData, expRd);
    if (sel) begin
      chk("R8 cliReady low during pause", cliReady, 0);
      chk("R7 txValid", txValid, 1);
      chk("R7 txSop", txSop, b == 0);
      chk("R7 txEop", txEop, b == 7);
      chk("R7 txEmpty", txEmpty, (b == 7) ? 3'd4 : 3'd0);
      chk((b == 2) ? "R6 quanta beat" : "R5 frame data", txData, refBeat(b, xo));
    end else begin
      chk("R11 cliReady", cliReady, txReady);
      chk("R11 txValid", txValid, cliValid);
      if (cliValid) begin
        chk("R11 txData", txData, cliData);
        chk("R11 txSop", txSop, cliSop);
        chk("R11 txEop", txEop, cliEop);
        chk("R11 txEmpty", txEmpty, cliEmpty);
      end
    end
    // independent observer of pause frames on the line
    if (txValid && txReady) begin
      if (txSop && txData[63:16] == 48'h0180C2000001) obsCnt = 1;
      else if (obsCnt > 0) begin
        if (obsCnt == 2) seenQ.push_back(txData[63:48]);
        obsCnt++;
        if (txEop) obsCnt = 0;
      end
    end
    // next reference state
    done = 0;
    if (start) begin
      mSend = 1; mXoff = xo; mBeat = txReady ? 1 : 0;
    end else if (mSend && txReady) begin
      if (mBeat == 7) begin mSend = 0; done = 1; end
      else mBeat++;
    end
    dm = done ? (mXoff ? 2'b10 : 2'b01) : 2'b00;
    cliAcc = !sel && cliValid && txReady;
    if (cliAcc && cliSop && !cliEop) mInFrame = 1;
    else if (cliAcc && cliEop) mInFrame = 0;
    mPin = (mPin & ~dm) | reqIn;
    mCmd = mCmd & ~dm;
    if (regWr) begin
      case (regAddr)
        3'd0: mCmd = mCmd | regWrData[1:0];
        3'd1: mEn = regWrData[0];
        3'd2: mQ = regWrData[15:0];
        3'd3: mLo = regWrData;
        3'd4: mHi = regWrData[15:0];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWr = 1; regAddr = a; regWrData = d;
    step();
    regWr = 0; regAddr = 3'd0;
  endtask

  task automatic expectQ(input string tag, input logic [15:0] e);
    nCmp++;
    if (seenQ.size() == 0) begin
      nBad++;
      $display("FAIL %s actual=none expected=%h", tag, e);
    end else begin
      logic [15:0] a;
      a = seenQ.pop_front();
      if (a !== e) begin
        nBad++;
        $display("FAIL %s actual=%h expected=%h", tag, a, e);
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    #1;
    chk("R1 txValid after reset", txValid, 0);
    chk("R1 cliReady after reset", cliReady, txReady);
    for (int a = 0; a < 5; a++) begin
      regAddr = 3'(a);
      #1 chk("R1 register reset value", regRdData, 0);
    end
    regAddr = 3'd0;
    idle(2);

    // program address and quanta
    wr(3'd3, 32'h23174ACB);
    wr(3'd4, 32'h0000001C);
    wr(3'd2, 32'h0000FFFF);

    // R2/R4: pin XOFF while disabled stays pending
    reqIn = 2'b10; step(); reqIn = 2'b00;
    idle(6);
    chk("R4 no frame while disabled", seenQ.size(), 0);
    wr(3'd1, 32'h1);
    idle(12);
    expectQ("R2 pin XOFF frame quanta", 16'hFFFF);

    // R3: register XON with readback of self-clearing bit
    wr(3'd0, 32'h1);
    idle(12);
    expectQ("R3 register XON frame quanta", 16'h0000);

    // R9: both at once
    reqIn = 2'b11; step(); reqIn = 2'b00;
    idle(20);
    expectQ("R9 XOFF served first", 16'hFFFF);
    expectQ("R9 XON served second", 16'h0000);

    // R8: request during an open client packet
    cliValid = 1; cliSop = 1; cliData = 64'hA1A2A3A4A5A6A7A8; step();
    cliSop = 0; cliData = 64'hB1B2B3B4B5B6B7B8;
    wr(3'd0, 32'h2);
    cliData = 64'hC1C2C3C4C5C6C7C8; idle(3);
    chk("R8 no pause while client open", seenQ.size(), 0);
    cliEop = 1; cliEmpty = 3'd3; cliData = 64'hD1D2D3D4D5D6D7D8; step();
    cliValid = 0; cliEop = 0; cliEmpty = 0;
    idle(12);
    expectQ("R8 pause after client end", 16'hFFFF);

    // R8: request and client start in the same cycle
    cliValid = 1; cliSop = 1; cliEop = 1; cliData = 64'h0123456789ABCDEF;
    wr(3'd0, 32'h1);
    idle(10);
    cliValid = 0; cliSop = 0; cliEop = 0;
    idle(4);
    expectQ("R8 pause wins start boundary", 16'h0000);

    // R10: backpressure with a new quanta
    wr(3'd2, 32'h00001234);
    reqIn = 2'b10; step(); reqIn = 2'b00;
    for (int i = 0; i < 30; i++) begin
      txReady = (i % 3) != 0;
      step();
    end
    txReady = 1;
    idle(6);
    expectQ("R10 stalled frame quanta", 16'h1234);
    chk("R10 no extra frames", seenQ.size(), 0);

    // R4: command pending while disabled
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h1);
    idle(5);
    chk("R4 nothing sent while disabled", seenQ.size(), 0);
    wr(3'd1, 32'h1);
    idle(12);
    expectQ("R4 pending sent after enable", 16'h0000);

    finish_run();
  end
endmodule